// File: doc/BRIEF.md
# Two-Half XOR-Shift Random Word Generator

This block is a free-running pseudo-random source for use inside a larger chip. Its state is two W-bit halves. Each enabled clock, a single level of XOR gates and fixed wiring advances the halves: two rotates and one plain left shift. The output word is the modular sum of the two halves. That adder sits outside the feedback loop, so it only affects output quality and never shortens the iteration path. The state can never be all zero, but the summed word can be zero.

A seed strobe loads both halves. An all-zero seed is replaced by the reset seed. The loaded seed is kept, and a flag pulses each time the state returns to it, which allows period measurement. A bounded iteration counter stops when the period is found or when it wraps to zero. An optional decimated port registers one word every N clocks, for consumers that sample slowly. A second port carries the sum without its weak least significant bit.

Top module: `xsr_prng_top`

## Requirements
- R1: While reset is low, the halves hold s0=1, s1=0. This gives rnd_word=1, iter_cnt=0, and cnt_done, period_hit and dec_valid all 0.
- R2: rnd_word equals (s0+s1) mod 2^W of the current state, before that cycle's update. A value of zero is a legal output.
- R3: On each enabled clock, with t = s0^s1, the next s0 is rotl(s0,A)^t^(t<<B) truncated to W bits, and the next s1 is rotl(t,C). The B term is a logical shift, with zero fill. The state is never all zero.
- R4: rnd_hi always equals bits [W-1:1] of rnd_word.
- R5: With en low and no seed strobe, the state, rnd_word and iter_cnt keep their values.
- R6: seed_ld takes priority over en. On the next clock the halves become seed_a and seed_b, this pair becomes the stored seed, and iter_cnt and cnt_done clear.
- R7: A seed strobe with seed_a=0 and seed_b=0 loads s0=1, s1=0 instead.
- R8: period_hit is 1 exactly when the state equals the stored seed and at least one step has been taken since the last reset or load. iter_cnt counts steps, modulo 2^CNT_W. When a step returns the state to the seed, iter_cnt equals the period, cnt_done rises, and both then hold until the next load.
- R9: If iter_cnt wraps to zero before the period is found, it stops at 0 and cnt_done rises.
- R10: When DEC_EN=1, dec_valid is high for one cycle at every DEC_N-th clock after reset. In that cycle, dec_word holds the rnd_word of the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance the state this clock |
| seed_ld | input | 1 | Load seed halves this clock |
| seed_a | input | W | Seed for half s0 |
| seed_b | input | W | Seed for half s1 |
| rnd_word | output | W | Sum of the two halves |
| rnd_hi | output | W-1 | rnd_word without its bit 0 |
| dec_word | output | W | Decimated registered word |
| dec_valid | output | 1 | Pulse marking a new dec_word |
| period_hit | output | 1 | State equals stored seed after stepping |
| iter_cnt | output | CNT_W | Steps since reset or load, frozen when done |
| cnt_done | output | 1 | Counter stopped by period or wrap |

## Verification
The checks assume that reset is held for at least one clock edge and that the seed inputs are stable in any cycle where seed_ld is high. The bench changes inputs only at falling edges. It holds reset for several cycles before the first load. The hold, load and freeze properties also assume that a seed strobe is never treated as a step. The bench exercises this by raising en and seed_ld together, and by loading while the counter is frozen.

// File: rtl/xsr_pkg.sv
package xsr_pkg;

    // Counter condition of the period detector
    typedef enum logic [1:0] {
        CNT_RUN  = 2'd0,
        CNT_HIT  = 2'd1,
        CNT_WRAP = 2'd2
    } cnt_state_e;

    localparam int unsigned RESET_S0 = 1;
    localparam int unsigned RESET_S1 = 0;

endpackage

// File: rtl/xsr_step.sv
module xsr_step #(
    parameter int unsigned W = 12,
    parameter int unsigned A = 8,
    parameter int unsigned B = 2,
    parameter int unsigned C = 3
) (
    input  logic [W-1:0] cur_s0,
    input  logic [W-1:0] cur_s1,
    output logic [W-1:0] nxt_s0,
    output logic [W-1:0] nxt_s1
);
    localparam int unsigned AR = A % W;
    localparam int unsigned CR = C % W;

    logic [W-1:0] mix;
    logic [W-1:0] rot_a;
    logic [W-1:0] rot_c;
    logic [W-1:0] shl_b;

    // rotates are pure wiring, built bit by bit
    for (genvar i = 0; i < W; i++) begin : g_rot
        assign rot_a[i] = cur_s0[(i + W - AR) % W];
        assign rot_c[i] = mix[(i + W - CR) % W];
    end

    // plain logical shift with zero fill
    for (genvar j = 0; j < W; j++) begin : g_shl
        if (j >= B) begin : g_src
            assign shl_b[j] = mix[j - B];
        end else begin : g_zero
            assign shl_b[j] = 1'b0;
        end
    end

    always_comb begin
        mix    = cur_s0 ^ cur_s1;
        nxt_s0 = rot_a ^ mix ^ shl_b;
        nxt_s1 = rot_c;
    end
endmodule

// File: rtl/xsr_sum.sv
module xsr_sum #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] cur_s0,
    input  logic [W-1:0] cur_s1,
    output logic [W-1:0] sum_word,
    output logic [W-2:0] sum_hi
);
    always_comb begin
        sum_word = cur_s0 + cur_s1;
        sum_hi   = sum_word[W-1:1];
    end
endmodule

// File: rtl/xsr_period.sv
module xsr_period
    import xsr_pkg::*;
#(
    parameter int unsigned W     = 12,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             load,
    input  logic [W-1:0]     load_s0,
    input  logic [W-1:0]     load_s1,
    input  logic [W-1:0]     cur_s0,
    input  logic [W-1:0]     cur_s1,
    input  logic [W-1:0]     nxt_s0,
    input  logic [W-1:0]     nxt_s1,
    output logic             period_hit,
    output logic [CNT_W-1:0] iter_cnt,
    output logic             cnt_done
);
    typedef struct packed {
        logic [W-1:0]     sd0;
        logic [W-1:0]     sd1;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        cnt_state_e       cst;
    } per_t;

    per_t per_d, per_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             back_home;

    always_comb begin
        per_d     = per_q;
        cnt_inc   = per_q.cnt + 1'b1;
        back_home = (nxt_s0 == per_q.sd0) && (nxt_s1 == per_q.sd1);
        if (load) begin
            per_d.sd0   = load_s0;
            per_d.sd1   = load_s1;
            per_d.armed = 1'b0;
            per_d.cnt   = '0;
            per_d.cst   = CNT_RUN;
        end else if (adv) begin
            per_d.armed = 1'b1;
            if (per_q.cst == CNT_RUN) begin
                per_d.cnt = cnt_inc;
                if (back_home) begin
                    per_d.cst = CNT_HIT;
                end else if (cnt_inc == '0) begin
                    per_d.cst = CNT_WRAP;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q.sd0   <= W'(RESET_S0);
            per_q.sd1   <= W'(RESET_S1);
            per_q.armed <= 1'b0;
            per_q.cnt   <= '0;
            per_q.cst   <= CNT_RUN;
        end else begin
            per_q <= per_d;
        end
    end

    assign period_hit = per_q.armed && (cur_s0 == per_q.sd0) && (cur_s1 == per_q.sd1);
    assign iter_cnt   = per_q.cnt;
    assign cnt_done   = (per_q.cst != CNT_RUN);
endmodule

// File: rtl/xsr_decim.sv
module xsr_decim #(
    parameter int unsigned W      = 12,
    parameter int unsigned DEC_N  = 16,
    parameter bit          DEC_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] dec_word,
    output logic         dec_valid
);
    localparam int unsigned DCW = (DEC_N > 1) ? $clog2(DEC_N) : 1;
    localparam logic [DCW-1:0] LAST = DCW'(DEC_N - 1);

    if (DEC_EN) begin : g_on
        typedef struct packed {
            logic [DCW-1:0] tick;
            logic [W-1:0]   word;
            logic           vld;
        } dec_t;

        dec_t dec_d, dec_q;

        always_comb begin
            dec_d     = dec_q;
            dec_d.vld = 1'b0;
            if (dec_q.tick == LAST) begin
                dec_d.tick = '0;
                dec_d.word = word_in;
                dec_d.vld  = 1'b1;
            end else begin
                dec_d.tick = dec_q.tick + 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dec_q <= '0;
            end else begin
                dec_q <= dec_d;
            end
        end

        assign dec_word  = dec_q.word;
        assign dec_valid = dec_q.vld;
    end else begin : g_off
        assign dec_word  = '0;
        assign dec_valid = 1'b0;
    end
endmodule

// File: rtl/xsr_prng_top.sv
module xsr_prng_top
    import xsr_pkg::*;
#(
    parameter int unsigned W      = 12,
    parameter int unsigned A      = 8,
    parameter int unsigned B      = 2,
    parameter int unsigned C      = 3,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DEC_N  = 16,
    parameter bit          DEC_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             seed_ld,
    input  logic [W-1:0]     seed_a,
    input  logic [W-1:0]     seed_b,
    output logic [W-1:0]     rnd_word,
    output logic [W-2:0]     rnd_hi,
    output logic [W-1:0]     dec_word,
    output logic             dec_valid,
    output logic             period_hit,
    output logic [CNT_W-1:0] iter_cnt,
    output logic             cnt_done
);
    typedef struct packed {
        logic [W-1:0] s0;
        logic [W-1:0] s1;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] nxt_s0, nxt_s1;
    logic [W-1:0] ld_s0, ld_s1;
    logic [W-1:0] cur_s0, cur_s1;
    logic         step;

    assign cur_s0 = st_q.s0;
    assign cur_s1 = st_q.s1;

    xsr_step #(.W(W), .A(A), .B(B), .C(C)) u_step (
        .cur_s0 (cur_s0),
        .cur_s1 (cur_s1),
        .nxt_s0 (nxt_s0),
        .nxt_s1 (nxt_s1)
    );

    always_comb begin
        if ((seed_a == '0) && (seed_b == '0)) begin
            ld_s0 = W'(RESET_S0);
            ld_s1 = W'(RESET_S1);
        end else begin
            ld_s0 = seed_a;
            ld_s1 = seed_b;
        end
        step = en && !seed_ld;
        st_d = st_q;
        if (seed_ld) begin
            st_d.s0 = ld_s0;
            st_d.s1 = ld_s1;
        end else if (en) begin
            st_d.s0 = nxt_s0;
            st_d.s1 = nxt_s1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.s0 <= W'(RESET_S0);
            st_q.s1 <= W'(RESET_S1);
        end else begin
            st_q <= st_d;
        end
    end

    xsr_sum #(.W(W)) u_sum (
        .cur_s0   (cur_s0),
        .cur_s1   (cur_s1),
        .sum_word (rnd_word),
        .sum_hi   (rnd_hi)
    );

    xsr_period #(.W(W), .CNT_W(CNT_W)) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (step),
        .load       (seed_ld),
        .load_s0    (ld_s0),
        .load_s1    (ld_s1),
        .cur_s0     (cur_s0),
        .cur_s1     (cur_s1),
        .nxt_s0     (nxt_s0),
        .nxt_s1     (nxt_s1),
        .period_hit (period_hit),
        .iter_cnt   (iter_cnt),
        .cnt_done   (cnt_done)
    );

    xsr_decim #(.W(W), .DEC_N(DEC_N), .DEC_EN(DEC_EN)) u_decim (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_in   (rnd_word),
        .dec_word  (dec_word),
        .dec_valid (dec_valid)
    );
endmodule

// File: rtl/xsr_prng_chk.sv
module xsr_prng_chk #(
    parameter int unsigned W     = 12,
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             seed_ld,
    input logic [W-1:0]     seed_a,
    input logic [W-1:0]     seed_b,
    input logic [W-1:0]     s0,
    input logic [W-1:0]     s1,
    input logic [W-1:0]     rnd_word,
    input logic [CNT_W-1:0] iter_cnt,
    input logic             cnt_done,
    input logic [W-1:0]     dec_word,
    input logic             dec_valid
);
    // R3
    state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s0 != '0) || (s1 != '0));

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !seed_ld) |=> ($stable(s0) && $stable(s1) && $stable(iter_cnt)));

    // R6
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_ld && ((seed_a != '0) || (seed_b != '0)))
        |=> ((s0 == $past(seed_a)) && (s1 == $past(seed_b)) && (iter_cnt == '0) && !cnt_done));

    // R7
    zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_ld && (seed_a == '0) && (seed_b == '0)) |=> ((s0 == W'(1)) && (s1 == '0)));

    // R8
    count_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_done && !seed_ld) |=> (cnt_done && $stable(iter_cnt)));

    // R10
    dec_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_word == $past(rnd_word)));
endmodule

bind xsr_prng_top xsr_prng_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .seed_ld   (seed_ld),
    .seed_a    (seed_a),
    .seed_b    (seed_b),
    .s0        (cur_s0),
    .s1        (cur_s1),
    .rnd_word  (rnd_word),
    .iter_cnt  (iter_cnt),
    .cnt_done  (cnt_done),
    .dec_word  (dec_word),
    .dec_valid (dec_valid)
);

// File: tb/xsr_prng_top_tb.sv
module xsr_prng_top_tb;
    localparam int unsigned W          = 8;
    localparam int unsigned A          = 6;
    localparam int unsigned B          = 1;
    localparam int unsigned C          = 3;
    localparam int unsigned CNT_W      = 16;
    localparam int unsigned CNT_S      = 3;
    localparam int unsigned DEC_N      = 16;
    localparam int          CLK_PERIOD = 10;
    localparam int          WATCHDOG   = 195000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic seed_ld = 1'b0;
    logic [W-1:0] seed_a = '0;
    logic [W-1:0] seed_b = '0;

    logic [W-1:0]     rnd_word, dec_word, rnd_word_w, dec_word_w;
    logic [W-2:0]     rnd_hi, rnd_hi_w;
    logic             dec_valid, period_hit, cnt_done;
    logic             dec_valid_w, period_hit_w, cnt_done_w;
    logic [CNT_W-1:0] iter_cnt;
    logic [CNT_S-1:0] iter_cnt_w;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // model state
    logic [W-1:0]     ms0, ms1, msd0, msd1;
    logic             marmed;
    logic [CNT_W-1:0] mc;
    logic             md;
    logic [CNT_S-1:0] mc2;
    logic             md2;

    always #(CLK_PERIOD/2) clk = ~clk;

    xsr_prng_top #(.W(W), .A(A), .B(B), .C(C), .CNT_W(CNT_W), .DEC_N(DEC_N), .DEC_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .seed_ld(seed_ld), .seed_a(seed_a), .seed_b(seed_b),
        .rnd_word(rnd_word), .rnd_hi(rnd_hi), .dec_word(dec_word), .dec_valid(dec_valid),
        .period_hit(period_hit), .iter_cnt(iter_cnt), .cnt_done(cnt_done));

    xsr_prng_top #(.W(W), .A(A), .B(B), .C(C), .CNT_W(CNT_S), .DEC_N(DEC_N), .DEC_EN(1'b0)) u_dut_wrap (
        .clk(clk), .rst_n(rst_n), .en(en), .seed_ld(seed_ld), .seed_a(seed_a), .seed_b(seed_b),
        .rnd_word(rnd_word_w), .rnd_hi(rnd_hi_w), .dec_word(dec_word_w), .dec_valid(dec_valid_w),
        .period_hit(period_hit_w), .iter_cnt(iter_cnt_w), .cnt_done(cnt_done_w));

    function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int unsigned n);
        logic [2*W-1:0] dbl;
        dbl = {x, x} << n;
        return dbl[2*W-1:W];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [W-1:0] t, n0, n1;
        t  = ms0 ^ ms1;
        n0 = rotl(ms0, A) ^ t ^ (t << B);
        n1 = rotl(t, C);
        ms0 = n0;
        ms1 = n1;
    endtask

    task automatic check_all();
        logic [W-1:0] es;
        es = ms0 + ms1;
        chk(rnd_word == es, "R2 R3 word", int'(rnd_word), int'(es));
        chk(rnd_hi == es[W-1:1], "R4 high bits", int'(rnd_hi), int'(es[W-1:1]));
        chk(period_hit == (marmed && ms0 == msd0 && ms1 == msd1), "R8 period flag",
            int'(period_hit), int'(marmed && ms0 == msd0 && ms1 == msd1));
        chk(iter_cnt == mc && cnt_done == md, "R8 counter",
            int'({iter_cnt, cnt_done}), int'({mc, md}));
        chk(iter_cnt_w == mc2 && cnt_done_w == md2, "R9 wrap counter",
            int'({iter_cnt_w, cnt_done_w}), int'({mc2, md2}));
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic tick(input logic e, input logic ld, input logic [W-1:0] a, input logic [W-1:0] b);
        en = e; seed_ld = ld; seed_a = a; seed_b = b;
        @(posedge clk);
        if (ld) begin
            if (a == '0 && b == '0) begin ms0 = W'(1); ms1 = '0; end
            else begin ms0 = a; ms1 = b; end
            msd0 = ms0; msd1 = ms1;
            marmed = 1'b0; mc = '0; md = 1'b0; mc2 = '0; md2 = 1'b0;
        end else if (e) begin
            model_step();
            marmed = 1'b1;
            if (!md) begin
                mc = mc + 1'b1;
                if ((ms0 == msd0 && ms1 == msd1) || mc == '0) md = 1'b1;
            end
            if (!md2) begin
                mc2 = mc2 + 1'b1;
                if ((ms0 == msd0 && ms1 == msd1) || mc2 == '0) md2 = 1'b1;
            end
        end
        @(negedge clk);
        seed_ld = 1'b0;
        check_all();
    endtask

    // decimation monitor
    int edges_since_rst = 0;
    logic [W-1:0] prev_word = '0;
    always @(posedge clk) begin
        cycles++;
        if (rst_n) edges_since_rst++;
    end
    always @(negedge clk) begin
        if (rst_n) begin
            // R10
            chk(dec_valid == (edges_since_rst > 0 && edges_since_rst % DEC_N == 0),
                "R10 pulse timing", int'(dec_valid), int'(edges_since_rst % DEC_N == 0));
            if (dec_valid) chk(dec_word == prev_word, "R10 captured word", int'(dec_word), int'(prev_word));
        end
        prev_word = rnd_word;
    end

    always @(posedge clk) begin
        if (cycles > WATCHDOG && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    int period;
    logic [W-1:0] hold_w;
    logic [CNT_W-1:0] hold_c;

    initial begin
        ms0 = W'(1); ms1 = '0; msd0 = W'(1); msd1 = '0;
        marmed = 1'b0; mc = '0; md = 1'b0; mc2 = '0; md2 = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(rnd_word == W'(1), "R1 reset word", int'(rnd_word), 1);
        chk(iter_cnt == '0 && !cnt_done && !period_hit && !dec_valid, "R1 reset flags",
            int'({iter_cnt, cnt_done, period_hit, dec_valid}), 0);
        rst_n = 1'b1;

        // full period from the reset seed
        period = 0;
        do begin
            tick(1'b1, 1'b0, '0, '0);
            period++;
        end while (!(ms0 == msd0 && ms1 == msd1) && period < 70000);
        chk(iter_cnt == CNT_W'(period) && cnt_done && period_hit, "R8 period found",
            int'(iter_cnt), period);
        if (period >= (1 << CNT_S))
            chk(iter_cnt_w == '0 && cnt_done_w, "R9 stopped at wrap", int'(iter_cnt_w), 0);

        // keep stepping: count frozen
        repeat (5) tick(1'b1, 1'b0, '0, '0);
        chk(iter_cnt == CNT_W'(period) && cnt_done, "R8 frozen", int'(iter_cnt), period);

        // enable low holds everything
        hold_w = rnd_word; hold_c = iter_cnt;
        repeat (6) tick(1'b0, 1'b0, '0, '0);
        chk(rnd_word == hold_w && iter_cnt == hold_c, "R5 hold", int'(rnd_word), int'(hold_w));
        for (int i = 0; i < 20; i++) tick(i[0], 1'b0, '0, '0);

        // load with enable also high: load wins
        tick(1'b1, 1'b1, 8'h35, 8'hA7);
        chk(rnd_word == W'(8'h35 + 8'hA7) && iter_cnt == '0 && !cnt_done && !period_hit,
            "R6 load priority", int'(rnd_word), int'(W'(8'h35 + 8'hA7)));
        period = 0;
        do begin
            tick(1'b1, 1'b0, '0, '0);
            period++;
        end while (!(ms0 == msd0 && ms1 == msd1) && period < 70000);
        chk(cnt_done && period_hit && iter_cnt == CNT_W'(period), "R6 R8 loaded seed period",
            int'(iter_cnt), period);

        // zero seed
        tick(1'b0, 1'b1, '0, '0);
        chk(rnd_word == W'(1) && iter_cnt == '0, "R7 zero seed", int'(rnd_word), 1);
        repeat (30) tick(1'b1, 1'b0, '0, '0);
        chk(iter_cnt == CNT_W'(30), "R7 steps after zero seed", int'(iter_cnt), 30);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule